// File: doc/BRIEF.md
# SD Host Command Issue and Inhibit Path

This block is the command half of an SD host controller. Software loads a 32-bit argument and then writes a 16-bit command word. That write launches a command towards the card and sets the command-line inhibit flag. When the command needs the data lines, either for a data transfer or because the card signals busy after its response, the data-line inhibit flag is set as well. Both flags show in a 32-bit present-state word, together with the live levels of the four data lines.

The card side is abstracted. The block presents a one-cycle launch strobe carrying the index, the argument and the response kind. The card model answers with a full response frame and a valid strobe, or with a timeout strobe, plus a flag that marks a bad checksum. The block removes the checksum byte when it stores a response. It raises command-complete, timeout and error bits, which software clears by writing ones. For busy-type responses it holds the data-line inhibit until data line 0 returns high. Bit-level line timing and checksum generation belong to other blocks.

Top module: `sdc_cmd_path`

## Requirements
- R1: A command word write launches a command while the command-line inhibit is low. In the cycle after the write, `card_cmd_valid` pulses for one cycle. It carries the index taken from word bits [13:8], the argument last written, and the response kind taken from word bits [1:0].
- R2: The command-line inhibit is present-state bit 0. It is high from the cycle after an accepted write until the response is captured or a timeout is seen. For response kind 00 it falls one cycle after the launch, and command complete rises at the same time.
- R3: A command word write made while the command-line inhibit is high is ignored: nothing is launched, and the launched index does not change.
- R4: The response kind is encoded as follows: 00 no response, 01 a 136-bit frame, 10 a 48-bit frame, 11 a 48-bit frame followed by busy. For a 48-bit frame, `rsp_data[31:0]` takes frame bits [39:8] and `rsp_data[127:32]` keeps its previous value.
- R5: For a 136-bit frame, `rsp_data[119:0]` takes frame bits [127:8] and `rsp_data[127:120]` is zero, so the checksum byte is dropped.
- R6: The status bits are: [0] command complete, [1] error summary, [2] timeout, [3] checksum error, [4] index error. A captured response sets bit 0. A timeout sets bits 2 and 1 and leaves bit 0 clear.
- R7: When word bit 4 enables the index check and the response is a 48-bit kind, a returned index (frame bits [45:40]) that differs from the issued index sets bits 4 and 1. When word bit 3 enables the checksum check, a capture with the bad-checksum flag high sets bits 3 and 1.
- R8: A status bit is cleared by a clear write with a one in its mask position. A status event in the same cycle wins over the clear.
- R9: The data-line inhibit is present-state bit 1. It is set at launch when word bit 5 (data present) is one or when the kind is 11. For kind 11 it falls at the first clock edge after the capture edge at which data line 0 is high. For data commands it falls on the `xfer_done` pulse. A timeout clears it.
- R10: Present-state bits [23:20] show `dat_lines[3:0]`, and all unused present-state bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arg_wr | input | 1 | Argument write strobe |
| arg_wdata | input | 32 | Argument value |
| cmd_wr | input | 1 | Command word write strobe, launches a command |
| cmd_wdata | input | 16 | Command word |
| sts_clr_wr | input | 1 | Status clear strobe |
| sts_clr_mask | input | 5 | Ones clear the matching status bits |
| xfer_done | input | 1 | Transfer complete pulse from the data path |
| dat_lines | input | 4 | Data line levels |
| card_rsp_valid | input | 1 | Response frame valid |
| card_rsp_timeout | input | 1 | Card gave no response |
| card_rsp_crc_bad | input | 1 | Frame checksum mismatch |
| card_rsp_bits | input | 136 | Response frame, 48-bit frames in bits [47:0] |
| card_cmd_valid | output | 1 | One-cycle launch strobe |
| card_cmd_idx | output | 6 | Launched command index |
| card_cmd_arg | output | 32 | Launched argument |
| card_cmd_kind | output | 2 | Launched response kind |
| prsnt | output | 32 | Present-state word |
| sts | output | 5 | Status bits |
| rsp_data | output | 128 | Stored response |

## Verification
The bench builds the block with its default parameters: a 32-bit argument, a 136-bit frame, 128 bits of response storage and an 8-bit checksum byte. With these values a full long frame, with a recognisable header and checksum byte, can be checked bit for bit against the shifted image. Short captures that follow long ones show that the upper words are kept. The same values bring within reach the index field at frame bits [45:40] and data line 0 at present-state bit 20. This allows the index-error, busy-release and line-mirror cases to be driven directly.

// File: rtl/sdc_pkg.sv
// Shared types for the SD command path.
// Assumes the 16-bit command word layout that the response decoder depends on.
package sdc_pkg;

    localparam int CMD_W = 16;
    localparam int IDX_W = 6;
    localparam int STS_W = 5;

    // Status bit positions
    localparam int ST_DONE = 0;
    localparam int ST_ERR  = 1;
    localparam int ST_TMO  = 2;
    localparam int ST_CRC  = 3;
    localparam int ST_IDX  = 4;

    typedef enum logic [1:0] {
        RSP_NONE       = 2'b00,
        RSP_LONG       = 2'b01,
        RSP_SHORT      = 2'b10,
        RSP_SHORT_BUSY = 2'b11
    } rsp_kind_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'b00,
        S_WAIT = 2'b01,
        S_FIN  = 2'b10
    } seq_state_e;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             data_present;
        logic             idx_chk;
        logic             crc_chk;
        rsp_kind_e        kind;
    } cmd_fields_t;

    // Split a command word into its fields
    function automatic cmd_fields_t decode_cmd(input logic [CMD_W-1:0] w);
        cmd_fields_t f;
        f.idx          = w[13:8];
        f.data_present = w[5];
        f.idx_chk      = w[4];
        f.crc_chk      = w[3];
        f.kind         = rsp_kind_e'(w[1:0]);
        return f;
    endfunction

endpackage

// File: rtl/sdc_cmd_seq.sv
// Command sequencer: accepts command writes, launches them and tracks both inhibit flags.
// Assumes the card answers a launched command with one valid or one timeout strobe.
module sdc_cmd_seq
    import sdc_pkg::*;
#(
    parameter int ARG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_wdata,
    input  logic [ARG_W-1:0] arg_q,
    input  logic             card_rsp_valid,
    input  logic             card_rsp_timeout,
    input  logic             xfer_done,
    input  logic             dat0,
    output logic             inhibit_cmd,
    output logic             inhibit_dat,
    output logic             card_cmd_valid,
    output logic [IDX_W-1:0] card_cmd_idx,
    output logic [ARG_W-1:0] card_cmd_arg,
    output cmd_fields_t      cur,
    output logic             cap_en,
    output logic             ev_done,
    output logic             ev_tmo
);

    seq_state_e  state;
    logic        pend_busy;
    logic        pend_xfer;
    logic        busy_armed;
    cmd_fields_t dec;
    logic        unused_cmd_bits;

    assign dec             = decode_cmd(cmd_wdata);
    assign unused_cmd_bits = ^{cmd_wdata[7:6], cmd_wdata[2]};

    // Sequencer state, launch registers and pending data-line reasons
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state          <= S_IDLE;
            inhibit_cmd    <= 1'b0;
            pend_busy      <= 1'b0;
            pend_xfer      <= 1'b0;
            busy_armed     <= 1'b0;
            card_cmd_valid <= 1'b0;
            card_cmd_idx   <= '0;
            card_cmd_arg   <= '0;
            cur            <= '0;
        end else begin
            card_cmd_valid <= 1'b0;
            if (busy_armed && dat0) begin
                pend_busy  <= 1'b0;
                busy_armed <= 1'b0;
            end
            if (pend_xfer && xfer_done) begin
                pend_xfer <= 1'b0;
            end
            unique case (state)
                S_IDLE: begin
                    if (cmd_wr) begin
                        cur            <= dec;
                        card_cmd_valid <= 1'b1;
                        card_cmd_idx   <= dec.idx;
                        card_cmd_arg   <= arg_q;
                        inhibit_cmd    <= 1'b1;
                        if (dec.data_present) begin
                            pend_xfer <= 1'b1;
                        end
                        if (dec.kind == RSP_SHORT_BUSY) begin
                            pend_busy  <= 1'b1;
                            busy_armed <= 1'b0;
                        end
                        state <= (dec.kind == RSP_NONE) ? S_FIN : S_WAIT;
                    end
                end
                S_WAIT: begin
                    if (card_rsp_valid) begin
                        inhibit_cmd <= 1'b0;
                        state       <= S_IDLE;
                        if (cur.kind == RSP_SHORT_BUSY) begin
                            busy_armed <= 1'b1;
                        end
                    end else if (card_rsp_timeout) begin
                        inhibit_cmd <= 1'b0;
                        pend_busy   <= 1'b0;
                        pend_xfer   <= 1'b0;
                        busy_armed  <= 1'b0;
                        state       <= S_IDLE;
                    end
                end
                S_FIN: begin
                    inhibit_cmd <= 1'b0;
                    state       <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Event strobes towards capture and status logic
    always_comb begin
        cap_en      = (state == S_WAIT) && card_rsp_valid;
        ev_tmo      = (state == S_WAIT) && !card_rsp_valid && card_rsp_timeout;
        ev_done     = cap_en || (state == S_FIN);
        inhibit_dat = pend_busy || pend_xfer;
    end

endmodule

// File: rtl/sdc_rsp_store.sv
// Response storage: keeps the frame body without its checksum byte, word by word.
// Assumes a 48-bit frame sits in the low bits of the frame bus.
module sdc_rsp_store
    import sdc_pkg::*;
#(
    parameter int RSP_W    = 136,
    parameter int STORE_W  = 128,
    parameter int CRC_BITS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_en,
    input  cmd_fields_t        cur,
    input  logic               crc_bad,
    input  logic [RSP_W-1:0]   frame,
    output logic [STORE_W-1:0] rsp_data,
    output logic               ev_crc,
    output logic               ev_idx
);

    localparam int WORD_W = 32;
    localparam int NWORDS = STORE_W / WORD_W;
    localparam int IDX_LO = CRC_BITS + WORD_W;

    logic [STORE_W-1:0] long_img;
    logic [IDX_W-1:0]   ret_idx;
    logic               is_long;
    logic               unused_frame_bits;

    assign long_img          = {{CRC_BITS{1'b0}}, frame[STORE_W-1:CRC_BITS]};
    assign ret_idx           = frame[IDX_LO +: IDX_W];
    assign is_long           = (cur.kind == RSP_LONG);
    assign unused_frame_bits = ^{frame[RSP_W-1:STORE_W], frame[CRC_BITS-1:0], cur.data_present};

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        logic [WORD_W-1:0] q;
        // Load this word from a long frame, or from a short frame for word 0
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (cap_en && (is_long || (w == 0))) begin
                q <= is_long ? long_img[w*WORD_W +: WORD_W] : frame[CRC_BITS +: WORD_W];
            end
        end
        assign rsp_data[w*WORD_W +: WORD_W] = q;
    end

    // Error events found while capturing
    always_comb begin
        ev_crc = cap_en && cur.crc_chk && crc_bad;
        ev_idx = cap_en && cur.idx_chk && cur.kind[1] && (ret_idx != cur.idx);
    end

endmodule

// File: rtl/sdc_irq_status.sv
// Status bits with write-one-to-clear; a new event beats a clear in the same cycle.
module sdc_irq_status
    import sdc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_done,
    input  logic             ev_tmo,
    input  logic             ev_crc,
    input  logic             ev_idx,
    input  logic             clr_wr,
    input  logic [STS_W-1:0] clr_mask,
    output logic [STS_W-1:0] sts
);

    logic [STS_W-1:0] set_v;
    logic [STS_W-1:0] clr_v;

    // Collect this cycle's set events
    always_comb begin
        set_v          = '0;
        set_v[ST_DONE] = ev_done;
        set_v[ST_TMO]  = ev_tmo;
        set_v[ST_CRC]  = ev_crc;
        set_v[ST_IDX]  = ev_idx;
        set_v[ST_ERR]  = ev_tmo || ev_crc || ev_idx;
        clr_v          = clr_wr ? clr_mask : '0;
    end

    // Status register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts <= '0;
        end else begin
            sts <= (sts & ~clr_v) | set_v;
        end
    end

endmodule

// File: rtl/sdc_cmd_path.sv
// Top of the SD command path: argument register, sequencer, response store, status.
// Assumes one register write at a time from the software side.
module sdc_cmd_path
    import sdc_pkg::*;
#(
    parameter int ARG_W    = 32,
    parameter int RSP_W    = 136,
    parameter int STORE_W  = 128,
    parameter int CRC_BITS = 8,
    parameter int DAT_W    = 4,
    parameter int PRS_W    = 32,
    parameter int DAT_POS  = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arg_wr,
    input  logic [ARG_W-1:0]   arg_wdata,
    input  logic               cmd_wr,
    input  logic [15:0]        cmd_wdata,
    input  logic               sts_clr_wr,
    input  logic [4:0]         sts_clr_mask,
    input  logic               xfer_done,
    input  logic [DAT_W-1:0]   dat_lines,
    input  logic               card_rsp_valid,
    input  logic               card_rsp_timeout,
    input  logic               card_rsp_crc_bad,
    input  logic [RSP_W-1:0]   card_rsp_bits,
    output logic               card_cmd_valid,
    output logic [5:0]         card_cmd_idx,
    output logic [ARG_W-1:0]   card_cmd_arg,
    output logic [1:0]         card_cmd_kind,
    output logic [PRS_W-1:0]   prsnt,
    output logic [4:0]         sts,
    output logic [STORE_W-1:0] rsp_data
);

    logic [ARG_W-1:0] arg_q;
    logic             inhibit_cmd;
    logic             inhibit_dat;
    cmd_fields_t      cur;
    logic             cap_en;
    logic             ev_done;
    logic             ev_tmo;
    logic             ev_crc;
    logic             ev_idx;

    // Argument register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arg_q <= '0;
        end else if (arg_wr) begin
            arg_q <= arg_wdata;
        end
    end

    sdc_cmd_seq #(.ARG_W(ARG_W)) seq_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .cmd_wr           (cmd_wr),
        .cmd_wdata        (cmd_wdata),
        .arg_q            (arg_q),
        .card_rsp_valid   (card_rsp_valid),
        .card_rsp_timeout (card_rsp_timeout),
        .xfer_done        (xfer_done),
        .dat0             (dat_lines[0]),
        .inhibit_cmd      (inhibit_cmd),
        .inhibit_dat      (inhibit_dat),
        .card_cmd_valid   (card_cmd_valid),
        .card_cmd_idx     (card_cmd_idx),
        .card_cmd_arg     (card_cmd_arg),
        .cur              (cur),
        .cap_en           (cap_en),
        .ev_done          (ev_done),
        .ev_tmo           (ev_tmo)
    );

    sdc_rsp_store #(
        .RSP_W    (RSP_W),
        .STORE_W  (STORE_W),
        .CRC_BITS (CRC_BITS)
    ) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .cur      (cur),
        .crc_bad  (card_rsp_crc_bad),
        .frame    (card_rsp_bits),
        .rsp_data (rsp_data),
        .ev_crc   (ev_crc),
        .ev_idx   (ev_idx)
    );

    sdc_irq_status status_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_done  (ev_done),
        .ev_tmo   (ev_tmo),
        .ev_crc   (ev_crc),
        .ev_idx   (ev_idx),
        .clr_wr   (sts_clr_wr),
        .clr_mask (sts_clr_mask),
        .sts      (sts)
    );

    // Present-state word and launched kind
    always_comb begin
        prsnt                     = '0;
        prsnt[0]                  = inhibit_cmd;
        prsnt[1]                  = inhibit_dat;
        prsnt[DAT_POS +: DAT_W]   = dat_lines;
        card_cmd_kind             = cur.kind;
    end

endmodule

// File: rtl/sdc_cmd_path_chk.sv
// Protocol checker for the command path, bound to the top module.
module sdc_cmd_path_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_wr,
    input logic       card_cmd_valid,
    input logic       inh_cmd,
    input logic       inh_dat,
    input logic [4:0] sts,
    input logic       dat0,
    input logic       xfer_done,
    input logic       card_rsp_timeout,
    input logic [7:0] rsp_top
);

    // A launch only happens with the command line marked busy
    assert_launch_inhibited_R1: assert property (@(posedge clk) disable iff (!rst_n)
        card_cmd_valid |-> inh_cmd);

    // A write during inhibit launches nothing
    assert_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (inh_cmd && cmd_wr) |=> !card_cmd_valid);

    // Dropping the command inhibit comes with completion or timeout status
    assert_release_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(inh_cmd) |-> (sts[0] || sts[2]));

    // A timeout never raises completion in the same cycle
    assert_timeout_not_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts[2]) |-> !$rose(sts[0]));

    // The data inhibit falls only for a line, transfer or timeout cause
    assert_dat_release_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(inh_dat) |-> $past(dat0 || xfer_done || card_rsp_timeout));

    // Index or checksum error is always summarised
    assert_error_summary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sts[4]) || $rose(sts[3])) |-> sts[1]);

    // The checksum byte never reaches the top of storage
    assert_top_byte_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_top == 8'h00);

endmodule

bind sdc_cmd_path sdc_cmd_path_chk chk_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .cmd_wr           (cmd_wr),
    .card_cmd_valid   (card_cmd_valid),
    .inh_cmd          (prsnt[0]),
    .inh_dat          (prsnt[1]),
    .sts              (sts),
    .dat0             (dat_lines[0]),
    .xfer_done        (xfer_done),
    .card_rsp_timeout (card_rsp_timeout),
    .rsp_top          (rsp_data[STORE_W-1 -: 8])
);

// File: tb/sdc_cmd_path_tb.sv
// Self-checking bench: a vector table walked by one loop, then directed corner cases.
module sdc_cmd_path_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         arg_wr = 1'b0;
    logic [31:0]  arg_wdata = '0;
    logic         cmd_wr = 1'b0;
    logic [15:0]  cmd_wdata = '0;
    logic         sts_clr_wr = 1'b0;
    logic [4:0]   sts_clr_mask = '0;
    logic         xfer_done = 1'b0;
    logic [3:0]   dat_lines = 4'hF;
    logic         card_rsp_valid = 1'b0;
    logic         card_rsp_timeout = 1'b0;
    logic         card_rsp_crc_bad = 1'b0;
    logic [135:0] card_rsp_bits = '0;
    logic         card_cmd_valid;
    logic [5:0]   card_cmd_idx;
    logic [31:0]  card_cmd_arg;
    logic [1:0]   card_cmd_kind;
    logic [31:0]  prsnt;
    logic [4:0]   sts;
    logic [127:0] rsp_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [127:0] exp_store = '0;

    always #5 clk = ~clk;

    sdc_cmd_path dut_i (
        .clk(clk), .rst_n(rst_n), .arg_wr(arg_wr), .arg_wdata(arg_wdata),
        .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .sts_clr_wr(sts_clr_wr),
        .sts_clr_mask(sts_clr_mask), .xfer_done(xfer_done), .dat_lines(dat_lines),
        .card_rsp_valid(card_rsp_valid), .card_rsp_timeout(card_rsp_timeout),
        .card_rsp_crc_bad(card_rsp_crc_bad), .card_rsp_bits(card_rsp_bits),
        .card_cmd_valid(card_cmd_valid), .card_cmd_idx(card_cmd_idx),
        .card_cmd_arg(card_cmd_arg), .card_cmd_kind(card_cmd_kind),
        .prsnt(prsnt), .sts(sts), .rsp_data(rsp_data)
    );

    typedef struct packed {
        logic [15:0] cmd;
        logic [31:0] arg;
        logic [31:0] pay;
        logic [5:0]  ridx;
        logic        tmo;
        logic        crcb;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{16'h0000, 32'h0000_0000, 32'h0000_0000, 6'd0,  1'b0, 1'b0},
        '{16'h0209, 32'hA5A5_0001, 32'h1234_5678, 6'd63, 1'b0, 1'b0},
        '{16'h111A, 32'h0000_0200, 32'hCAFE_F00D, 6'd17, 1'b0, 1'b0},
        '{16'h0D12, 32'h0000_0013, 32'h0BAD_BEEF, 6'd12, 1'b0, 1'b0},
        '{16'h370A, 32'h8000_0000, 32'h5555_AAAA, 6'd55, 1'b0, 1'b1},
        '{16'h081A, 32'h0000_01AA, 32'hFFFF_FFFF, 6'd8,  1'b1, 1'b0},
        '{16'h0901, 32'h0001_0000, 32'h8765_4321, 6'd0,  1'b0, 1'b1},
        '{16'h0302, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 6'd40, 1'b0, 1'b0}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [135:0] act, input logic [135:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [135:0] mk_frame(input vec_t v);
        if (v.cmd[1:0] == 2'b01)
            return {8'h3F, v.pay, ~v.pay, v.pay ^ 32'h5A5A_5A5A, v.pay[23:0], 8'hC3};
        return {88'h0, 2'b00, v.ridx, v.pay, 8'h5B};
    endfunction

    function automatic logic [4:0] exp_sts(input vec_t v);
        logic c;
        logic i;
        if (v.tmo) return 5'b00110;
        c = v.cmd[3] & v.crcb;
        i = v.cmd[4] & v.cmd[1] & (v.ridx != v.cmd[13:8]);
        return {i, c, 1'b0, c | i, 1'b1};
    endfunction

    task automatic clear_all();
        sts_clr_wr = 1'b1; sts_clr_mask = 5'h1F;
        tick();
        sts_clr_wr = 1'b0; sts_clr_mask = '0;
    endtask

    task automatic launch(input logic [15:0] w, input logic [31:0] a);
        arg_wr = 1'b1; arg_wdata = a;
        tick();
        arg_wr = 1'b0;
        cmd_wr = 1'b1; cmd_wdata = w;
        tick();
        cmd_wr = 1'b0;
    endtask

    task automatic respond(input logic [135:0] f, input logic tmo, input logic crcb);
        card_rsp_bits = f; card_rsp_valid = !tmo; card_rsp_timeout = tmo; card_rsp_crc_bad = crcb;
        tick();
        card_rsp_valid = 1'b0; card_rsp_timeout = 1'b0; card_rsp_crc_bad = 1'b0;
    endtask

    task automatic run_vec(input vec_t v);
        logic [135:0] f;
        clear_all();
        launch(v.cmd, v.arg);
        chk("R1 launch strobe", 136'(card_cmd_valid), 136'(1));
        chk("R1 launch index", 136'(card_cmd_idx), 136'(v.cmd[13:8]));
        chk("R1 launch argument", 136'(card_cmd_arg), 136'(v.arg));
        chk("R4 launch kind", 136'(card_cmd_kind), 136'(v.cmd[1:0]));
        chk("R2 inhibit set", 136'(prsnt[0]), 136'(1));
        if (v.cmd[1:0] == 2'b00) begin
            tick();
            chk("R2 no-response release", 136'(prsnt[0]), 136'(0));
            chk("R6 no-response status", 136'(sts), 136'(5'b00001));
        end else begin
            f = mk_frame(v);
            respond(f, v.tmo, v.crcb);
            if (!v.tmo) begin
                if (v.cmd[1:0] == 2'b01) exp_store = {8'h00, f[127:8]};
                else exp_store[31:0] = v.pay;
            end
            chk("R2 inhibit released", 136'(prsnt[0]), 136'(0));
            chk("R6 R7 status", 136'(sts), 136'(exp_sts(v)));
            chk("R4 R5 stored response", 136'(rsp_data), 136'(exp_store));
        end
        chk("R1 strobe one cycle", 136'(card_cmd_valid), 136'(0));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R2 reset inhibits", 136'(prsnt[1:0]), 136'(0));
        chk("R6 reset status", 136'(sts), 136'(0));
        chk("R4 reset response", 136'(rsp_data), 136'(0));
        chk("R1 reset strobe", 136'(card_cmd_valid), 136'(0));

        for (int k = 0; k < NV; k++) run_vec(VECS[k]);

        // R10: line mirror
        dat_lines = 4'b0101;
        #1;
        chk("R10 line mirror", 136'(prsnt), 136'(32'h0050_0000));
        dat_lines = 4'hF;
        #1;

        // R3: write during inhibit is ignored
        clear_all();
        launch(16'h0502, 32'h1);
        cmd_wr = 1'b1; cmd_wdata = 16'h0600;
        tick();
        cmd_wr = 1'b0;
        chk("R3 no second launch", 136'(card_cmd_valid), 136'(0));
        chk("R3 index kept", 136'(card_cmd_idx), 136'(5));
        chk("R3 inhibit still set", 136'(prsnt[0]), 136'(1));
        respond({88'h0, 2'b00, 6'd5, 32'h3, 8'h00}, 1'b0, 1'b0);
        tick();
        chk("R3 nothing launched later", 136'(card_cmd_valid), 136'(0));
        chk("R3 index after", 136'(card_cmd_idx), 136'(5));

        // R9: busy held while data line 0 low
        dat_lines = 4'b1110;
        launch(16'h0703, 32'h0);
        chk("R9 busy sets dat inhibit", 136'(prsnt[1]), 136'(1));
        respond({88'h0, 2'b00, 6'd7, 32'h9, 8'h00}, 1'b0, 1'b0);
        chk("R9 cmd released", 136'(prsnt[0]), 136'(0));
        tick(); tick();
        chk("R9 busy held", 136'(prsnt[1]), 136'(1));
        dat_lines = 4'b1111;
        tick();
        chk("R9 busy released", 136'(prsnt[1]), 136'(0));

        // R9: data command held until transfer done
        launch(16'h1122, 32'h0);
        chk("R9 data sets dat inhibit", 136'(prsnt[1]), 136'(1));
        respond('0, 1'b0, 1'b0);
        tick();
        chk("R9 data held", 136'(prsnt[1]), 136'(1));
        xfer_done = 1'b1;
        tick();
        xfer_done = 1'b0;
        chk("R9 data released", 136'(prsnt[1]), 136'(0));

        // R9 R6: timeout clears both inhibits
        clear_all();
        dat_lines = 4'b1110;
        launch(16'h0703, 32'h0);
        respond('0, 1'b1, 1'b0);
        chk("R9 timeout clears", 136'(prsnt[1:0]), 136'(0));
        chk("R6 timeout status", 136'(sts), 136'(5'b00110));
        dat_lines = 4'hF;

        // R8: write-one-to-clear and set wins
        sts_clr_wr = 1'b1; sts_clr_mask = 5'b00100;
        tick();
        sts_clr_wr = 1'b0;
        chk("R8 selective clear", 136'(sts), 136'(5'b00010));
        launch(16'h0000, 32'h0);
        sts_clr_wr = 1'b1; sts_clr_mask = 5'b00001;
        tick();
        sts_clr_wr = 1'b0;
        chk("R8 set beats clear", 136'(sts[0]), 136'(1));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule